// File: doc/BRIEF.md
# SDRAM Forced-Command Front End

This block sits between a host bus and an SDRAM controller. A small register selects how host accesses to the SDRAM window are treated. In normal mode each access is handed on unchanged as a request to the downstream access engine. In any other mode the access is not forwarded. It becomes one command that the block drives onto the SDRAM command pins. Software uses this to walk a device through its power-up sequence: precharge all banks, auto-refresh, and program the mode and extended mode registers.

A forced command takes one command cycle. A fixed number of NOP cycles follows, and then a one-cycle acknowledge to the host. For mode-register loads, the offset of the host address within the window is placed on the bank and address pins, so that offset is the value the device stores. The block remembers whether the last forced command was an all-banks precharge. An auto-refresh requested without one is replaced by a NOP and raises a sticky error flag. Deep power-down mode drives the power-down command and holds clock enable low until software writes a normal mode code.

The sequencer has five states:
- IDLE waits for an access.
- FWD holds a forwarded normal access until the engine acknowledges it.
- ISSUE is the command slot.
- PAD counts the NOP cycles.
- ACK acknowledges the host.

The transitions are:
- IDLE to FWD on an access in normal mode.
- IDLE to ISSUE on an access in a forced mode.
- IDLE to ACK on an access while powered down.
- FWD to IDLE on the engine acknowledge.
- ISSUE to PAD, or straight to ACK when no NOP cycles are configured.
- PAD to ACK after the last NOP cycle.
- ACK to IDLE.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset the following hold:
  - `cfg_rdata` is 0, which selects normal mode.
  - `sd_cke` is 1.
  - The command pins carry NOP ({cs_n,ras_n,cas_n,we_n}=0111) with `sd_a` and `sd_ba` zero.
  - `host_ready` and `nrm_req` are 0.
- R2: With mode code 0 or 7, an access raises `nrm_req` in the cycle after acceptance. `nrm_wr` and `nrm_addr` carry the latched host values, and `host_ready` follows `nrm_ack`. No SDRAM command is driven.
- R3: With a forced mode (codes 1 to 6), a read or a write access gives the following sequence, and `nrm_req` stays 0:
  - The access is accepted at a clock edge.
  - The command appears in the next cycle, for exactly one cycle.
  - NOP_CYC (default 2) NOP cycles follow.
  - `host_ready` is then high for one cycle.
- R4: Code 1 issues a NOP. Code 2 issues precharge-all as pins 0010 with `sd_a[10]`=1 and all other address and bank bits 0.
- R5: Codes 3 (load mode) and 5 (extended load mode) issue pins 0000. {`sd_ba`,`sd_a`} equals the low BA_W+A_W bits of `host_addr`.
- R6: Code 4 issues auto-refresh (pins 0001) only when the most recent forced command was a precharge-all. Otherwise it issues a NOP and sets the error flag at `cfg_rdata[8]`. The flag stays set until the next register write clears it.
- R7: Any forced command other than precharge-all clears the precharge record. A second auto-refresh in a row is therefore refused.
- R8: Code 6 issues pins 0110 with `sd_cke` low. `sd_cke` then stays low, and later accesses are acknowledged in the cycle after acceptance with no command. Writing code 0 or 7 raises `sd_cke` from the cycle after the write.
- R9: A register write in the same cycle as an access acceptance does not alter that access. The access uses the mode code held before the write.
- R10: `cfg_rdata[2:0]` returns the last written code, including 7. Bits 7:3 read 0, and the register changes only on `cfg_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 3 | Mode code to write |
| cfg_rdata | output | 9 | Readback: code in [2:0], error flag in [8] |
| host_req | input | 1 | Host access to the SDRAM window, held until ready |
| host_wr | input | 1 | Access is a write |
| host_addr | input | HADDR_W | Address offset within the window |
| host_ready | output | 1 | Access complete |
| nrm_req | output | 1 | Forwarded normal access request |
| nrm_wr | output | 1 | Forwarded write flag |
| nrm_addr | output | HADDR_W | Forwarded address |
| nrm_ack | input | 1 | Engine accepts forwarded access |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BA_W | Bank address |
| sd_a | output | A_W | Address |
| sd_cke | output | 1 | Clock enable, low in deep power-down |

## Verification
A mode register write and the acceptance of a host access can land on the same clock edge. The question is which mode code the access obeys. The bench provokes this with precharge mode programmed: it raises the access request and a write of the NOP code in one cycle. It then judges that the command pins still show precharge-all with address bit 10 set, and that the readback afterwards shows the new NOP code.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

    localparam int MODE_W  = 3;
    localparam int ERR_BIT = 8;

    typedef enum logic [2:0] {
        MD_NORMAL = 3'd0,
        MD_NOP    = 3'd1,
        MD_PRE    = 3'd2,
        MD_LMR    = 3'd3,
        MD_AREF   = 3'd4,
        MD_ELMR   = 3'd5,
        MD_DPD    = 3'd6,
        MD_RSVD   = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        CK_NOP,
        CK_PRE,
        CK_LMR,
        CK_AREF,
        CK_ELMR,
        CK_DPD
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD,
        ST_ISSUE,
        ST_PAD,
        ST_ACK
    } state_e;

endpackage

// File: rtl/sdcf_mode_reg.sv
module sdcf_mode_reg
    import sdcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] cfg_wdata,
    output logic [MODE_W-1:0] mode_raw,
    output mode_e             mode,
    output logic              wr_normal
);

    logic [MODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (cfg_wr) begin
            code_q <= cfg_wdata;
        end
    end

    // reserved code folds onto normal decoding
    always_comb begin
        if (code_q == MD_RSVD) begin
            mode = MD_NORMAL;
        end else begin
            mode = mode_e'(code_q);
        end
    end

    assign mode_raw  = code_q;
    assign wr_normal = cfg_wr && ((cfg_wdata == MD_NORMAL) || (cfg_wdata == MD_RSVD));

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(mode_raw)); // R10

endmodule

// File: rtl/sdcf_seq.sv
module sdcf_seq
    import sdcf_pkg::*;
#(
    parameter int HADDR_W = 16,
    parameter int NOP_CYC = 2
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [HADDR_W-1:0] host_addr,
    input  mode_e              mode,
    input  logic               cfg_wr,
    input  logic               wr_normal,
    input  logic               nrm_ack,
    output logic               host_ready,
    output logic               nrm_req,
    output logic               nrm_wr,
    output logic [HADDR_W-1:0] nrm_addr,
    output cmd_e               bus_cmd,
    output logic [HADDR_W-1:0] cmd_addr,
    output logic               dpd_active,
    output logic               err,
    output logic               pre_done
);

    localparam int CNT_W = (NOP_CYC > 1) ? $clog2(NOP_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'((NOP_CYC > 0) ? NOP_CYC - 1 : 0);

    state_e             state_q, state_d;
    cmd_e               cmd_q, cmd_d;
    logic [HADDR_W-1:0] addr_q;
    logic               wr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               dpd_q, err_q, pre_q;
    logic               aref_fail;
    logic               accept;

    assign accept = (state_q == ST_IDLE) && host_req;

    // next-state and command choice
    always_comb begin
        state_d   = state_q;
        cmd_d     = cmd_q;
        aref_fail = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    if (dpd_q) begin
                        state_d = ST_ACK;
                    end else if (mode == MD_NORMAL) begin
                        state_d = ST_FWD;
                    end else begin
                        state_d = ST_ISSUE;
                        unique case (mode)
                            MD_PRE:  cmd_d = CK_PRE;
                            MD_LMR:  cmd_d = CK_LMR;
                            MD_ELMR: cmd_d = CK_ELMR;
                            MD_DPD:  cmd_d = CK_DPD;
                            MD_AREF: begin
                                cmd_d     = pre_q ? CK_AREF : CK_NOP;
                                aref_fail = !pre_q;
                            end
                            default: cmd_d = CK_NOP;
                        endcase
                    end
                end
            end
            ST_FWD: begin
                if (nrm_ack) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ISSUE: begin
                state_d = (NOP_CYC == 0) ? ST_ACK : ST_PAD;
            end
            ST_PAD: begin
                if (cnt_q == LAST) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // latched access and bookkeeping of precharge, power-down, error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CK_NOP;
            addr_q <= '0;
            wr_q   <= 1'b0;
            cnt_q  <= '0;
            dpd_q  <= 1'b0;
            err_q  <= 1'b0;
            pre_q  <= 1'b0;
        end else begin
            cmd_q <= cmd_d;
            if (accept) begin
                addr_q <= host_addr;
                wr_q   <= host_wr;
            end
            if (state_q == ST_PAD) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
            if (state_q == ST_ISSUE) begin
                pre_q <= (cmd_q == CK_PRE);
            end
            if (state_q == ST_ISSUE && cmd_q == CK_DPD) begin
                dpd_q <= 1'b1;
            end else if (wr_normal) begin
                dpd_q <= 1'b0;
            end
            if (accept && !dpd_q && aref_fail) begin
                err_q <= 1'b1;
            end else if (cfg_wr) begin
                err_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        host_ready = 1'b0;
        nrm_req    = 1'b0;
        bus_cmd    = CK_NOP;
        unique case (state_q)
            ST_FWD: begin
                nrm_req    = 1'b1;
                host_ready = nrm_ack;
            end
            ST_ISSUE: bus_cmd    = cmd_q;
            ST_ACK:   host_ready = 1'b1;
            default: ;
        endcase
    end

    assign nrm_wr     = wr_q;
    assign nrm_addr   = addr_q;
    assign cmd_addr   = addr_q;
    assign dpd_active = dpd_q;
    assign err        = err_q;
    assign pre_done   = pre_q;

    AST_FORCED_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && !nrm_req) |=> !host_ready); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !cfg_wr) |=> err); // R6

endmodule

// File: rtl/sdcf_cmd_enc.sv
module sdcf_cmd_enc
    import sdcf_pkg::*;
#(
    parameter int A_W  = 13,
    parameter int BA_W = 2
)(
    input  cmd_e                  cmd,
    input  logic [BA_W+A_W-1:0]   offset,
    input  logic                  dpd_active,
    output logic                  cs_n,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n,
    output logic [BA_W-1:0]       ba,
    output logic [A_W-1:0]        a,
    output logic                  cke
);

    logic [A_W-1:0] pre_addr;

    // all-banks flag sits on address bit 10 when the bus is wide enough
    generate
        if (A_W > 10) begin : g_a10
            always_comb begin
                pre_addr     = '0;
                pre_addr[10] = 1'b1;
            end
        end else begin : g_no_a10
            assign pre_addr = '0;
        end
    endgenerate

    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        ba = '0;
        a  = '0;
        unique case (cmd)
            CK_PRE: begin
                {cs_n, ras_n, cas_n, we_n} = 4'b0010;
                a = pre_addr;
            end
            CK_LMR, CK_ELMR: begin
                {cs_n, ras_n, cas_n, we_n} = 4'b0000;
                {ba, a} = offset;
            end
            CK_AREF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            CK_DPD:  {cs_n, ras_n, cas_n, we_n} = 4'b0110;
            default: ;
        endcase
    end

    assign cke = !(dpd_active || (cmd == CK_DPD));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdcf_pkg::*;
#(
    parameter int HADDR_W = 16,
    parameter int A_W     = 13,
    parameter int BA_W    = 2,
    parameter int NOP_CYC = 2
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [MODE_W-1:0]  cfg_wdata,
    output logic [ERR_BIT:0]   cfg_rdata,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [HADDR_W-1:0] host_addr,
    output logic               host_ready,
    output logic               nrm_req,
    output logic               nrm_wr,
    output logic [HADDR_W-1:0] nrm_addr,
    input  logic               nrm_ack,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [BA_W-1:0]    sd_ba,
    output logic [A_W-1:0]     sd_a,
    output logic               sd_cke
);

    localparam int OFS_W = BA_W + A_W;

    mode_e              mode;
    logic [MODE_W-1:0]  mode_raw;
    logic               wr_normal;
    cmd_e               bus_cmd;
    logic [HADDR_W-1:0] cmd_addr;
    logic               dpd_active, err, pre_done;
    logic               bus_busy;

    sdcf_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .mode_raw  (mode_raw),
        .mode      (mode),
        .wr_normal (wr_normal)
    );

    sdcf_seq #(.HADDR_W(HADDR_W), .NOP_CYC(NOP_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .mode       (mode),
        .cfg_wr     (cfg_wr),
        .wr_normal  (wr_normal),
        .nrm_ack    (nrm_ack),
        .host_ready (host_ready),
        .nrm_req    (nrm_req),
        .nrm_wr     (nrm_wr),
        .nrm_addr   (nrm_addr),
        .bus_cmd    (bus_cmd),
        .cmd_addr   (cmd_addr),
        .dpd_active (dpd_active),
        .err        (err),
        .pre_done   (pre_done)
    );

    sdcf_cmd_enc #(.A_W(A_W), .BA_W(BA_W)) u_enc (
        .cmd        (bus_cmd),
        .offset     (cmd_addr[OFS_W-1:0]),
        .dpd_active (dpd_active),
        .cs_n       (sd_cs_n),
        .ras_n      (sd_ras_n),
        .cas_n      (sd_cas_n),
        .we_n       (sd_we_n),
        .ba         (sd_ba),
        .a          (sd_a),
        .cke        (sd_cke)
    );

    always_comb begin
        cfg_rdata          = '0;
        cfg_rdata[MODE_W-1:0] = mode_raw;
        cfg_rdata[ERR_BIT] = err;
    end

    assign bus_busy = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111);

    AST_ONE_CMD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> !bus_busy); // R3
    AST_AREF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001) |-> pre_done); // R6
    AST_CKE_LOW_DPD: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_active |-> !sd_cke); // R8
    AST_NORMAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        nrm_req |-> !bus_busy); // R2

endmodule

// File: tb/sdram_cmd_front_tb.sv
module sdram_cmd_front_tb;

    localparam int HADDR_W = 16;
    localparam int A_W     = 13;
    localparam int BA_W    = 2;
    localparam int NOP_CYC = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_wr = 1'b0;
    logic [2:0]         cfg_wdata = '0;
    logic [8:0]         cfg_rdata;
    logic               host_req = 1'b0;
    logic               host_wr = 1'b0;
    logic [HADDR_W-1:0] host_addr = '0;
    logic               host_ready;
    logic               nrm_req, nrm_wr;
    logic [HADDR_W-1:0] nrm_addr;
    logic               nrm_ack = 1'b0;
    logic               sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BA_W-1:0]    sd_ba;
    logic [A_W-1:0]     sd_a;
    logic               sd_cke;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // results of the last forced access
    int          n_cmds, rdy_idx, cmd_idx;
    logic [3:0]  got_pins;
    logic [A_W-1:0]  got_a;
    logic [BA_W-1:0] got_ba;
    logic        got_cke;
    bit          saw_nrm;

    sdram_cmd_front #(.HADDR_W(HADDR_W), .A_W(A_W), .BA_W(BA_W), .NOP_CYC(NOP_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr), .host_ready(host_ready),
        .nrm_req(nrm_req), .nrm_wr(nrm_wr), .nrm_addr(nrm_addr), .nrm_ack(nrm_ack),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_cke(sd_cke)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] code);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = code;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // forced-mode access; optional register write in the acceptance cycle
    task automatic forced_access(input bit wr, input logic [HADDR_W-1:0] addr,
                                 input bit also_wr, input logic [2:0] code);
        n_cmds = 0; rdy_idx = -1; cmd_idx = -1; saw_nrm = 0;
        got_pins = 4'b0111; got_a = '0; got_ba = '0; got_cke = 1'b1;
        @(negedge clk);
        host_req  = 1'b1;
        host_wr   = wr;
        host_addr = addr;
        if (also_wr) begin
            cfg_wr    = 1'b1;
            cfg_wdata = code;
        end
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            cfg_wr = 1'b0;
            if (nrm_req) saw_nrm = 1;
            if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111 || sd_a != '0 || sd_ba != '0) begin
                n_cmds++;
                cmd_idx  = i;
                got_pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
                got_a    = sd_a;
                got_ba   = sd_ba;
                got_cke  = sd_cke;
            end
            if (host_ready) begin
                rdy_idx  = i;
                host_req = 1'b0;
                break;
            end
        end
        host_req = 1'b0;
    endtask

    task automatic t_reset();
        chk(cfg_rdata == 9'h000, "R1 readback", 32'(cfg_rdata), 0);
        chk(sd_cke == 1'b1, "R1 cke", 32'(sd_cke), 1);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a, sd_ba} == {4'b0111, 15'h0}, "R1 bus nop",
            32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
        chk(!host_ready && !nrm_req, "R1 idle handshakes", 32'({host_ready, nrm_req}), 0);
    endtask

    task automatic normal_access(input bit wr, input logic [HADDR_W-1:0] addr, input string tag);
        bit seen = 0;
        bit busy = 0;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = addr;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111) busy = 1;
            if (nrm_req) begin
                seen = 1;
                chk(i == 1, {tag, " req timing"}, 32'(i), 1);
                chk(nrm_wr == wr && nrm_addr == addr, {tag, " forwarded fields"},
                    32'({nrm_wr, nrm_addr}), 32'({wr, addr}));
                nrm_ack = 1'b1;
                #1;
                chk(host_ready == 1'b1, {tag, " ready follows ack"}, 32'(host_ready), 1);
                @(negedge clk);
                nrm_ack = 1'b0; host_req = 1'b0;
                break;
            end
        end
        chk(seen && !busy, {tag, " forwarded without command"}, 32'({seen, busy}), 32'h2);
    endtask

    task automatic t_normal();
        normal_access(1'b0, 16'h1234, "R2 code0");
        reg_write(3'd7);
        chk(cfg_rdata == 9'h007, "R10 reserved code readback", 32'(cfg_rdata), 7);
        normal_access(1'b1, 16'hBEEF, "R2 code7");
    endtask

    task automatic t_nop_pre_aref();
        reg_write(3'd1);
        forced_access(1'b0, 16'h0055, 1'b0, 3'd0);
        chk(n_cmds == 0 && rdy_idx == NOP_CYC + 2 && !saw_nrm, "R4 R3 forced nop read",
            32'({n_cmds[7:0], rdy_idx[7:0]}), 32'(NOP_CYC + 2));
        reg_write(3'd2);
        forced_access(1'b1, 16'h7FFF, 1'b0, 3'd0);
        chk(n_cmds == 1 && got_pins == 4'b0010 && got_a == 13'h0400 && got_ba == 0, "R4 precharge all",
            32'({got_pins, got_ba, got_a}), 32'({4'b0010, 2'b00, 13'h0400}));
        chk(cmd_idx == 1 && rdy_idx == NOP_CYC + 2 && !saw_nrm, "R3 slot and pad timing on write",
            32'({cmd_idx[7:0], rdy_idx[7:0]}), 32'({8'd1, 8'(NOP_CYC + 2)}));
        reg_write(3'd4);
        forced_access(1'b0, 16'h0000, 1'b0, 3'd0);
        chk(n_cmds == 1 && got_pins == 4'b0001, "R6 refresh after precharge", 32'(got_pins), 1);
        chk(cfg_rdata == 9'h004, "R6 no error after legal refresh", 32'(cfg_rdata), 4);
        forced_access(1'b0, 16'h0000, 1'b0, 3'd0);
        chk(n_cmds == 0 && rdy_idx == NOP_CYC + 2, "R7 second refresh refused", 32'(n_cmds), 0);
        chk(cfg_rdata == 9'h104, "R6 error flag set", 32'(cfg_rdata), 32'h104);
        reg_write(3'd4);
        chk(cfg_rdata == 9'h004, "R6 write clears error", 32'(cfg_rdata), 4);
    endtask

    task automatic t_lmr();
        reg_write(3'd3);
        forced_access(1'b0, 16'h6123, 1'b0, 3'd0);
        chk(n_cmds == 1 && got_pins == 4'b0000 && got_ba == 2'd3 && got_a == 13'h0123, "R5 load mode offset",
            32'({got_pins, got_ba, got_a}), 32'({4'b0000, 2'd3, 13'h0123}));
        reg_write(3'd5);
        forced_access(1'b1, 16'h4031, 1'b0, 3'd0);
        chk(n_cmds == 1 && got_pins == 4'b0000 && got_ba == 2'd2 && got_a == 13'h0031, "R5 extended load offset",
            32'({got_pins, got_ba, got_a}), 32'({4'b0000, 2'd2, 13'h0031}));
        // precharge record was cleared by the loads
        reg_write(3'd4);
        forced_access(1'b0, 16'h0000, 1'b0, 3'd0);
        chk(n_cmds == 0 && cfg_rdata[8] == 1'b1, "R7 refresh refused after load",
            32'({n_cmds[7:0], 7'h0, cfg_rdata[8]}), 1);
    endtask

    task automatic t_concurrent();
        reg_write(3'd2);
        forced_access(1'b0, 16'h0001, 1'b1, 3'd1);
        chk(n_cmds == 1 && got_pins == 4'b0010 && got_a == 13'h0400, "R9 old mode used",
            32'({got_pins, got_a}), 32'({4'b0010, 13'h0400}));
        chk(cfg_rdata == 9'h001, "R9 new code stored", 32'(cfg_rdata), 1);
    endtask

    task automatic t_dpd();
        reg_write(3'd6);
        forced_access(1'b1, 16'h0000, 1'b0, 3'd0);
        chk(n_cmds == 1 && got_pins == 4'b0110 && got_cke == 1'b0, "R8 power-down command",
            32'({got_pins, got_cke}), 32'({4'b0110, 1'b0}));
        chk(sd_cke == 1'b0, "R8 cke held low", 32'(sd_cke), 0);
        forced_access(1'b0, 16'h0000, 1'b0, 3'd0);
        chk(n_cmds == 0 && rdy_idx == 1 && sd_cke == 1'b0, "R8 access in power-down",
            32'({n_cmds[7:0], rdy_idx[7:0]}), 32'h0001);
        reg_write(3'd2);
        chk(sd_cke == 1'b0, "R8 non-normal write keeps power-down", 32'(sd_cke), 0);
        reg_write(3'd0);
        chk(sd_cke == 1'b1, "R8 cke released", 32'(sd_cke), 1);
        normal_access(1'b0, 16'h0042, "R2 after wake");
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_nop_pre_aref();
        t_lmr();
        t_concurrent();
        t_dpd();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule